// File: doc/BRIEF.md
# In-Order Commit Controller

This block holds the reorder list of an out-of-order core and retires instructions from its head in program order. The dispatch side allocates one entry per cycle at the tail. The execute and writeback side later marks an entry by slot number as commit-ready, stating whether it actually executed and whether it recorded a fault. Each cycle the controller walks the oldest entries, up to a fixed commit width. It retires every entry it can and stops at the first one it cannot.

Two kinds of entry reach the head without having executed: non-speculative instructions and uncached loads. They go back to the issue side through a single handoff port. The port carries a sequence number, plus an uncached flag and a load-queue index for loads. The controller then clears the entry's commit-ready flag, so the handoff happens once. The entry waits in place until writeback marks it again. A non-speculative handoff needs two things: it must be the first retire attempt of the cycle, and no stores may be waiting for writeback.

For each cycle the controller reports:
- how many entries retired, so a histogram counter can sample the count;
- how many destination registers were freed;
- the sequence number of the youngest retired entry.

Top module: `commit_ctrl`

## Requirements
- R1: After reset the list is empty (occupancy 0), alloc_ready is high, and done_valid, hand_valid and illegal are low.
- R2: No more than COMMIT_W entries retire in one cycle, always the oldest ones, and the rest stay for the following cycles.
- R3: Retirement stops at the first entry not marked commit-ready. Younger entries that are ready wait behind it, and all of them retire in one cycle once the gap is marked.
- R4: An unexecuted non-speculative entry at the head is handed off: hand_valid=1, hand_uncached=0, hand_seq = its sequence number. Its commit-ready flag is cleared, so it is handed off exactly once and stays in the list until it is marked again.
- R5: The non-speculative handoff is withheld in two cases: an older entry retired in the same cycle, or store_pend is high. The entry is handed off in a later cycle once both conditions are clear.
- R6: free_regs equals the sum of the destination counts of the entries retired in that cycle, and is 0 when nothing retires.
- R7: retire_cnt gives the number of entries retired in a cycle. When it is nonzero, done_valid is high and done_seq shows the youngest retired sequence number. done_seq holds its value otherwise. Occupancy drops by the number retired.
- R8: An unexecuted load that reaches the retire walk is handed off with hand_uncached=1, hand_seq and hand_lqidx = its load-queue index. Its commit-ready flag is cleared and the walk stops.
- R9: A ready entry with a fault blocks commit without retiring, unless it is marked as a no-op; a faulting no-op retires normally.
- R10: A ready, unexecuted entry that is neither non-speculative nor a load raises illegal and is not retired. At most one of hand_valid and illegal is high in any cycle.
- R11: With DEPTH entries held, alloc_ready is low and an allocation request is ignored. Entries are placed at slots 0,1,2,... in allocation order after reset (alloc_slot), wrapping modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| alloc_nonspec | input | 1 | Entry is non-speculative (commit-ready at allocation) |
| alloc_load | input | 1 | Entry is a load |
| alloc_nop | input | 1 | Entry is a no-op |
| alloc_lqidx | input | LQ_W | Load-queue index of the entry |
| alloc_ndest | input | DST_W | Number of destination registers |
| alloc_ready | output | 1 | List has a free entry |
| alloc_slot | output | $clog2(DEPTH) | Slot the next allocation will take |
| mark_valid | input | 1 | Mark an entry commit-ready |
| mark_slot | input | $clog2(DEPTH) | Slot being marked |
| mark_exec | input | 1 | Entry has executed |
| mark_fault | input | 1 | Entry recorded a fault |
| store_pend | input | 1 | Stores await writeback |
| done_valid | output | 1 | At least one entry retired |
| done_seq | output | SEQ_W | Youngest retired sequence number |
| retire_cnt | output | $clog2(COMMIT_W+1) | Entries retired this cycle |
| free_regs | output | see RTL | Destination registers freed this cycle |
| hand_valid | output | 1 | Handoff to the issue side |
| hand_seq | output | SEQ_W | Sequence number handed off |
| hand_uncached | output | 1 | Handoff is an uncached load |
| hand_lqidx | output | LQ_W | Load-queue index of the handed-off load |
| illegal | output | 1 | Unexecuted entry of no legal kind at the retire point |
| occupancy | output | $clog2(DEPTH+1) | Entries held |

## Verification
The retire walk is tried with several patterns:
- Six ready entries, marked youngest first, so the width limit splits them four then two and the per-cycle register sums can be compared.
- A hole in the ready pattern, which separates stopping at the first blocker from skipping over it.
- A non-speculative entry alone, behind a retiring entry, and under a pending store, which separates the three conditions that gate the handoff.
- An unexecuted load, faulting entries with and without the no-op mark, an illegal unexecuted entry, and a full list with a refused allocation, each of which shows whether the walk stops, retires or refuses in the right place.

// File: rtl/commit_ctrl.sv
module commit_ctrl #(
  parameter int DEPTH    = 16,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W    = 16,
  parameter int LQ_W     = 3,
  parameter int DST_W    = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int CNT_W   = $clog2(COMMIT_W + 1),
  localparam int FREE_W  = $clog2(COMMIT_W * ((1 << DST_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              alloc_nonspec,
  input  logic              alloc_load,
  input  logic              alloc_nop,
  input  logic [LQ_W-1:0]   alloc_lqidx,
  input  logic [DST_W-1:0]  alloc_ndest,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_slot,
  input  logic              mark_valid,
  input  logic [IDX_W-1:0]  mark_slot,
  input  logic              mark_exec,
  input  logic              mark_fault,
  input  logic              store_pend,
  output logic              done_valid,
  output logic [SEQ_W-1:0]  done_seq,
  output logic [CNT_W-1:0]  retire_cnt,
  output logic [FREE_W-1:0] free_regs,
  output logic              hand_valid,
  output logic [SEQ_W-1:0]  hand_seq,
  output logic              hand_uncached,
  output logic [LQ_W-1:0]   hand_lqidx,
  output logic              illegal,
  output logic [OCC_W-1:0]  occupancy
);
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [LQ_W-1:0]  lq_q  [DEPTH];
  logic [DST_W-1:0] nd_q  [DEPTH];
  logic [DEPTH-1:0] rdy_q, exe_q, flt_q, nsp_q, ld_q, nop_q;
  logic [IDX_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] count_q;

  assign alloc_ready = count_q < OCC_W'(DEPTH);
  assign alloc_slot  = tail_q;
  assign occupancy   = count_q;
  wire alloc_fire = alloc_valid && alloc_ready;

  logic [CNT_W-1:0]  n_c;
  logic [FREE_W-1:0] free_c;
  logic [SEQ_W-1:0]  last_c, hs_c;
  logic [LQ_W-1:0]   hl_c;
  logic [IDX_W-1:0]  clr_slot, s;
  logic              stop, hv_c, hu_c, ill_c;

  always_comb begin
    n_c = '0; free_c = '0; last_c = '0; hs_c = '0; hl_c = '0;
    clr_slot = '0; s = '0; stop = 1'b0; hv_c = 1'b0; hu_c = 1'b0; ill_c = 1'b0;
    for (int i = 0; i < COMMIT_W; i++) begin
      s = head_q + IDX_W'(i);
      if (!stop) begin
        if (OCC_W'(i) >= count_q || !rdy_q[s]) stop = 1'b1;
        else if (flt_q[s] && !nop_q[s]) stop = 1'b1;
        else if (!exe_q[s]) begin
          stop = 1'b1;
          if (nsp_q[s]) begin
            if (n_c == '0 && !store_pend) begin
              hv_c = 1'b1; hs_c = seq_q[s]; clr_slot = s;
            end
          end else if (ld_q[s]) begin
            hv_c = 1'b1; hu_c = 1'b1; hs_c = seq_q[s]; hl_c = lq_q[s]; clr_slot = s;
          end else ill_c = 1'b1;
        end else begin
          n_c    = n_c + 1'b1;
          free_c = free_c + FREE_W'(nd_q[s]);
          last_c = seq_q[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0; tail_q <= '0; count_q <= '0;
      rdy_q <= '0; exe_q <= '0; flt_q <= '0; nsp_q <= '0; ld_q <= '0; nop_q <= '0;
      done_valid <= 1'b0; done_seq <= '0; retire_cnt <= '0; free_regs <= '0;
      hand_valid <= 1'b0; hand_seq <= '0; hand_uncached <= 1'b0; hand_lqidx <= '0;
      illegal <= 1'b0;
    end else begin
      if (alloc_fire) begin
        seq_q[tail_q] <= alloc_seq;
        lq_q[tail_q]  <= alloc_lqidx;
        nd_q[tail_q]  <= alloc_ndest;
        nsp_q[tail_q] <= alloc_nonspec;
        ld_q[tail_q]  <= alloc_load;
        nop_q[tail_q] <= alloc_nop;
        rdy_q[tail_q] <= alloc_nonspec;
        exe_q[tail_q] <= 1'b0;
        flt_q[tail_q] <= 1'b0;
      end
      if (hv_c) rdy_q[clr_slot] <= 1'b0;
      if (mark_valid) begin
        rdy_q[mark_slot] <= 1'b1;
        exe_q[mark_slot] <= mark_exec;
        flt_q[mark_slot] <= mark_fault;
      end
      head_q  <= head_q + IDX_W'(n_c);
      tail_q  <= tail_q + IDX_W'(alloc_fire);
      count_q <= count_q + OCC_W'(alloc_fire) - OCC_W'(n_c);
      done_valid <= n_c != '0;
      if (n_c != '0) done_seq <= last_c;
      retire_cnt    <= n_c;
      free_regs     <= free_c;
      hand_valid    <= hv_c;
      hand_seq      <= hs_c;
      hand_uncached <= hu_c;
      hand_lqidx    <= hl_c;
      illegal       <= ill_c;
    end
  end

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_cnt) <= COMMIT_W);
  p_ns_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid && !hand_uncached |-> retire_cnt == '0 && !$past(store_pend));
  p_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_cnt == '0 |-> free_regs == '0 && !done_valid);
  p_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(occupancy) == int'($past(occupancy)) + int'($past(alloc_fire)) - int'(retire_cnt));
  p_one_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hand_valid, illegal}));
  p_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);
endmodule

// File: tb/sim_commit_ctrl.sv
module sim_commit_ctrl;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_nonspec = 0, alloc_load = 0, alloc_nop = 0;
  logic [15:0] alloc_seq = '0;
  logic [2:0] alloc_lqidx = '0;
  logic [1:0] alloc_ndest = '0;
  logic alloc_ready;
  logic [3:0] alloc_slot;
  logic mark_valid = 0, mark_exec = 0, mark_fault = 0, store_pend = 0;
  logic [3:0] mark_slot = '0;
  logic done_valid, hand_valid, hand_uncached, illegal;
  logic [15:0] done_seq, hand_seq;
  logic [2:0] retire_cnt, hand_lqidx;
  logic [3:0] free_regs;
  logic [4:0] occupancy;
  int vecs = 0, errs = 0, tail = 0;

  always #5 clk = ~clk;

  commit_ctrl u0 (.*);

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; step(2); rst_n = 1; tail = 0;
  endtask

  task automatic push(int sq, bit ns = 0, bit ld = 0, bit np = 0, int lq = 0, int nd = 0);
    alloc_valid = 1; alloc_seq = 16'(sq); alloc_nonspec = ns; alloc_load = ld;
    alloc_nop = np; alloc_lqidx = 3'(lq); alloc_ndest = 2'(nd);
    step();
    alloc_valid = 0; alloc_nonspec = 0; alloc_load = 0; alloc_nop = 0;
    tail = (tail + 1) % DEPTH;
  endtask

  task automatic mark(int slot, bit ex = 1, bit fl = 0);
    mark_valid = 1; mark_slot = 4'(slot % DEPTH); mark_exec = ex; mark_fault = fl;
    step();
    mark_valid = 0; mark_exec = 0; mark_fault = 0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 occupancy", occupancy, 0);
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 outputs idle", {done_valid, hand_valid, illegal}, 0);
    check("R11 first slot", alloc_slot, 0);
  endtask

  task automatic t_width;
    int b = tail;
    for (int i = 0; i < 6; i++) push(10 + i, 0, 0, 0, 0, i % 4);
    for (int i = 5; i >= 0; i--) mark(b + i);
    step();
    check("R2 first cycle count", retire_cnt, 4);
    check("R7 done_seq first", done_seq, 13);
    check("R7 done_valid", done_valid, 1);
    check("R6 free first", free_regs, 6);
    step();
    check("R2 second cycle count", retire_cnt, 2);
    check("R7 done_seq second", done_seq, 15);
    check("R6 free second", free_regs, 1);
    check("R7 occupancy drained", occupancy, 0);
  endtask

  task automatic t_gap;
    int b = tail;
    push(20, 0, 0, 0, 0, 1); push(21, 0, 0, 0, 0, 1); push(22, 0, 0, 0, 0, 1);
    mark(b); mark(b + 2);
    check("R3 head retires alone", retire_cnt, 1);
    check("R3 head seq", done_seq, 20);
    step();
    check("R3 younger waits", retire_cnt, 0);
    check("R3 occupancy held", occupancy, 2);
    mark(b + 1);
    step();
    check("R3 gap filled", retire_cnt, 2);
    check("R3 youngest", done_seq, 22);
  endtask

  task automatic t_nonspec;
    int b = tail;
    push(30, 1);
    step();
    check("R4 hand_valid", hand_valid, 1);
    check("R4 hand_uncached", hand_uncached, 0);
    check("R4 hand_seq", hand_seq, 30);
    step();
    check("R4 handed once", hand_valid, 0);
    check("R4 still held", occupancy, 1);
    mark(b);
    step();
    check("R4 retires after exec", done_seq, 30);
    check("R7 count one", retire_cnt, 1);
  endtask

  task automatic t_store;
    int b = tail;
    store_pend = 1;
    push(40, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R5 store pending stall", hand_valid, 0);
    end
    store_pend = 0;
    step();
    check("R5 handoff after stores", hand_valid, 1);
    check("R5 seq", hand_seq, 40);
    mark(b); step(2);
  endtask

  task automatic t_behind;
    int b = tail;
    push(50, 0, 0, 0, 0, 2); push(51, 1);
    mark(b);
    step();
    check("R5 older retired", retire_cnt, 1);
    check("R6 free two", free_regs, 2);
    check("R5 no handoff same cycle", hand_valid, 0);
    step();
    check("R5 handoff next cycle", hand_valid, 1);
    check("R5 behind seq", hand_seq, 51);
    mark(b + 1); step(2);
  endtask

  task automatic t_uncached;
    int b = tail;
    push(60, 0, 1, 0, 5);
    mark(b, 0);
    step();
    check("R8 hand_valid", hand_valid, 1);
    check("R8 uncached flag", hand_uncached, 1);
    check("R8 lq index", hand_lqidx, 5);
    check("R8 seq", hand_seq, 60);
    step();
    check("R8 handed once", hand_valid, 0);
    check("R8 held", occupancy, 1);
    mark(b);
    step();
    check("R8 retires later", done_seq, 60);
  endtask

  task automatic t_fault;
    int b = tail;
    push(70, 0, 0, 1); push(71);
    mark(b, 1, 1);
    step();
    check("R9 faulting nop retires", retire_cnt, 1);
    check("R9 nop seq", done_seq, 70);
    mark(b + 1, 1, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R9 fault blocks", retire_cnt, 0);
    end
    check("R9 fault held", occupancy, 1);
    do_reset();
  endtask

  task automatic t_illegal;
    int b = tail;
    push(80);
    mark(b, 0);
    step();
    check("R10 illegal raised", illegal, 1);
    check("R10 not retired", retire_cnt, 0);
    check("R10 no handoff", hand_valid, 0);
    step();
    check("R10 held", occupancy, 1);
    do_reset();
  endtask

  task automatic t_full;
    do_reset();
    for (int i = 0; i < DEPTH; i++) push(200 + i);
    check("R11 full ready low", alloc_ready, 0);
    check("R11 full occupancy", occupancy, DEPTH);
    alloc_valid = 1; alloc_seq = 16'd999; step(); alloc_valid = 0;
    check("R11 extra ignored", occupancy, DEPTH);
    for (int i = 0; i < DEPTH; i++) mark(i);
    step(4);
    check("R11 drained", occupancy, 0);
    check("R7 last seq held", done_seq, 215);
    check("R11 wrapped slot", alloc_slot, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_width();
    t_gap();
    t_nonspec();
    t_store();
    t_behind();
    t_uncached();
    t_fault();
    t_illegal();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule